// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous user interface and an external 32K x 8 static RAM that has no clock of its own. The user raises a request carrying a 15-bit address, a direction flag and a write byte. The sequencer then drives the memory's three active-low strobes (select, write, output), its address lines and the data bus through a separate output value and output-enable pair. When the access is complete it answers with a one-cycle acknowledge. On a read, the returned byte is valid during that same acknowledge cycle.

Every analog timing limit of the memory is given as a nanosecond parameter. Each one becomes a clock count: the ratio to the clock-period parameter, rounded up, with a floor of one cycle. The sequencer stretches each phase to the largest count that constrains it. During a write, the write window is the overlap of select low and write low, and the window closes when write-enable rises. The controller delays driving the bus by the memory's release time. After a read, it inserts an idle gap so the memory can let go of the bus before anything else happens.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and right after reset, all three strobes are high (1), the bus output-enable is 0 and the acknowledge is 0.
- R2: A write holds write-enable low for at least ceil(40 ns / T) cycles, and only while select is low. Output enable is high for the whole write. Select has been low for at least ceil(45 ns / T) cycles when the window closes. The address does not change while write-enable is low.
- R3: The controller's bus output-enable stays 0 for the first ceil(20 ns / T) cycles of the write-enable pulse. The driven byte is stable for at least ceil(25 ns / T) cycles before write-enable rises. The bus stays driven in the cycle in which write-enable rises and is released in the next cycle.
- R4: A read holds select and output-enable low with write-enable high for max(ceil(55 ns / T), ceil(25 ns / T)) cycles. The byte on the input bus in the last of those cycles is the one returned.
- R5: Acknowledge is high for exactly one cycle per transaction. For a write, it is high in the cycle in which write-enable returns high. For a read, it is high in the first cycle after output-enable returns high, and the read data port holds the captured byte in that cycle.
- R6: After a read, select stays high for at least max(1, ceil(20 ns / T)) cycles before the next access. The controller's bus output-enable is never 1 while output-enable is low.
- R7: A request is taken only while the controller is idle. The address, write data and direction inputs are latched when the request is taken, and changing them later has no effect on the access in progress.
- R8: A byte written to an address is returned by a later read of that same 15-bit address. All 15 address bits reach the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transaction request, held until acknowledge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with acknowledge |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address lines |
| mem_dq_o | output | 8 | Byte driven onto the memory data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Byte sampled from the memory data bus |

## Verification
The memory model returns a garbage byte until the read window has been open for the full access time. A sequencer that samples one cycle early therefore returns that garbage instead of the stored byte. The model checks the pulse length, the select length and the data stability window each time a write closes, so a shortened pulse or an early data release shows up as a commit error or a timing failure. The model also tags each location with the upper address bits, so a dropped or swapped high address bit returns a tag-miss value. A directed case changes the request fields mid-access; a design that does not latch them writes the wrong byte to the wrong place.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WADDR,
      ST_WPULSE,
      ST_WHOLD,
      ST_READ,
      ST_TURN
   } seq_state_t;

   // nanoseconds to clock cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_port_timer.sv
module sram_port_timer #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt,
   output logic          zero
);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sram_port_seq.sv
module sram_port_seq
   import sram_port_pkg::*;
#(
   parameter int unsigned N_PULSE = 5,
   parameter int unsigned N_LATE  = 2,
   parameter int unsigned N_READ  = 6,
   parameter int unsigned N_GAP   = 2,
   parameter int unsigned MIN_WP  = 4,
   parameter int unsigned CW      = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  logic req_we,
   output logic accept,
   output logic capture,
   output logic ack,
   output logic mem_ce_n,
   output logic mem_we_n,
   output logic mem_oe_n,
   output logic mem_dq_oe
);

   localparam logic [CW-1:0] PULSE_LD = CW'(N_PULSE - 1);
   localparam logic [CW-1:0] READ_LD  = CW'(N_READ - 1);
   localparam logic [CW-1:0] GAP_LD   = CW'(N_GAP - 1);
   localparam logic [CW-1:0] DRV_FROM = CW'(N_PULSE - 1 - N_LATE);
   localparam logic [CW:0]   MIN_WP_C = (CW+1)'(MIN_WP);

   seq_state_t    st_q, st_nx;
   logic          ld, ack_nx, cnt_zero;
   logic [CW-1:0] ld_val, cnt_q, cnt_nx;

   sram_port_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (ld),
      .load_val (ld_val),
      .cnt      (cnt_q),
      .zero     (cnt_zero)
   );

   always_comb begin
      st_nx   = st_q;
      ld      = 1'b0;
      ld_val  = '0;
      accept  = 1'b0;
      capture = 1'b0;
      ack_nx  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (req) begin
               accept = 1'b1;
               if (req_we) begin
                  st_nx = ST_WADDR;
               end else begin
                  st_nx  = ST_READ;
                  ld     = 1'b1;
                  ld_val = READ_LD;
               end
            end
         end
         ST_WADDR: begin
            st_nx  = ST_WPULSE;
            ld     = 1'b1;
            ld_val = PULSE_LD;
         end
         ST_WPULSE: begin
            if (cnt_zero) begin
               st_nx  = ST_WHOLD;
               ack_nx = 1'b1;
            end
         end
         ST_WHOLD: st_nx = ST_IDLE;
         ST_READ: begin
            if (cnt_zero) begin
               st_nx   = ST_TURN;
               ld      = 1'b1;
               ld_val  = GAP_LD;
               capture = 1'b1;
               ack_nx  = 1'b1;
            end
         end
         ST_TURN: begin
            if (cnt_zero) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   // counter value the timer will hold next cycle
   assign cnt_nx = ld ? ld_val : (cnt_zero ? '0 : cnt_q - 1'b1);

   // strobes are flops decoded from the next state: no decode glitches on pins
   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ST_IDLE;
         mem_ce_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         ack       <= 1'b0;
      end else begin
         st_q      <= st_nx;
         mem_ce_n  <= !(st_nx == ST_WADDR || st_nx == ST_WPULSE || st_nx == ST_READ);
         mem_we_n  <= (st_nx != ST_WPULSE);
         mem_oe_n  <= (st_nx != ST_READ);
         mem_dq_oe <= (st_nx == ST_WPULSE && cnt_nx <= DRV_FROM) || (st_nx == ST_WHOLD);
         ack       <= ack_nx;
      end
   end

   // checker-only pulse length counter
   logic [CW:0] we_low_cyc;
   always_ff @(posedge clk) begin
      if (rst || mem_we_n) we_low_cyc <= '0;
      else                 we_low_cyc <= we_low_cyc + 1'b1;
   end

   // R2
   we_only_selected_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> !mem_ce_n);
   // R2
   oe_off_in_write_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_oe_n);
   // R2
   we_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> we_low_cyc >= MIN_WP_C);
   // R3
   drive_release_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |=> !mem_dq_oe);
   // R6
   no_drive_in_read_chk: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> mem_oe_n);
   // R5
   ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);
   // R6
   read_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_oe_n) |=> (mem_ce_n && mem_oe_n));

endmodule

// File: rtl/sram_port_dpath.sv
module sram_port_dpath #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk) begin
      if (rst)         mem_addr <= '0;
      else if (accept) mem_addr <= req_addr;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)         mem_dq_o[b] <= 1'b0;
         else if (accept) mem_dq_o[b] <= req_wdata[b];
      end
      always_ff @(posedge clk) begin
         if (rst)          rsp_rdata[b] <= 1'b0;
         else if (capture) rsp_rdata[b] <= mem_dq_i[b];
      end
   end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
   import sram_port_pkg::*;
#(
   parameter int CLK_NS = 10,
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter int T_RC   = 55,
   parameter int T_AA   = 55,
   parameter int T_DOE  = 25,
   parameter int T_HZOE = 20,
   parameter int T_WC   = 55,
   parameter int T_SCE  = 45,
   parameter int T_AW   = 45,
   parameter int T_WP   = 40,
   parameter int T_SD   = 25,
   parameter int T_HZWE = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int NC_RC   = ns_to_cyc(T_RC, CLK_NS);
   localparam int NC_AA   = ns_to_cyc(T_AA, CLK_NS);
   localparam int NC_DOE  = ns_to_cyc(T_DOE, CLK_NS);
   localparam int NC_HZOE = ns_to_cyc(T_HZOE, CLK_NS);
   localparam int NC_WC   = ns_to_cyc(T_WC, CLK_NS);
   localparam int NC_SCE  = ns_to_cyc(T_SCE, CLK_NS);
   localparam int NC_AW   = ns_to_cyc(T_AW, CLK_NS);
   localparam int NC_WP   = ns_to_cyc(T_WP, CLK_NS);
   localparam int NC_SD   = ns_to_cyc(T_SD, CLK_NS);
   localparam int NC_HZWE = ns_to_cyc(T_HZWE, CLK_NS);

   // select and address lead the pulse by one cycle, the hold cycle trails it
   localparam int N_PULSE = max2(max2(NC_WP, NC_HZWE + NC_SD),
                                 max2(max2(NC_AW, NC_SCE) - 1, max2(NC_WC, 2) - 2));
   localparam int N_READ  = max2(max2(NC_RC, NC_AA), NC_DOE);
   localparam int N_GAP   = max2(1, NC_HZOE);
   localparam int CW      = $clog2(max2(max2(N_PULSE, N_READ), N_GAP) + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be at least 1");
   end

   logic accept, capture;

   sram_port_seq #(
      .N_PULSE (N_PULSE),
      .N_LATE  (NC_HZWE),
      .N_READ  (N_READ),
      .N_GAP   (N_GAP),
      .MIN_WP  (NC_WP),
      .CW      (CW)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .req_we    (req_we),
      .accept    (accept),
      .capture   (capture),
      .ack       (ack),
      .mem_ce_n  (mem_ce_n),
      .mem_we_n  (mem_we_n),
      .mem_oe_n  (mem_oe_n),
      .mem_dq_oe (mem_dq_oe)
   );

   sram_port_dpath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dpath (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .rsp_rdata (rsp_rdata)
   );

   // R2
   wr_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_port_ctrl_tb.sv
module sram_port_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RD_CYC  = (55 + CLK_PERIOD - 1) / CLK_PERIOD; // R4 access window
   localparam int WP_CYC  = (40 + CLK_PERIOD - 1) / CLK_PERIOD; // R2 pulse
   localparam int SCE_CYC = (45 + CLK_PERIOD - 1) / CLK_PERIOD; // R2 select
   localparam int LATE_CYC = (20 + CLK_PERIOD - 1) / CLK_PERIOD; // R3 late drive
   localparam int SD_CYC  = (25 + CLK_PERIOD - 1) / CLK_PERIOD; // R3 setup
   localparam int GAP_CYC = (LATE_CYC > 1) ? LATE_CYC : 1;        // R6
   localparam int NVEC = 12;

   // {we, addr[14:0], byte}: byte is write data or expected read data
   localparam logic [23:0] VEC [NVEC] = '{
      {1'b1, 15'h0000, 8'h3C}, {1'b1, 15'h7FFF, 8'hC3}, {1'b1, 15'h0155, 8'h5A},
      {1'b0, 15'h0000, 8'h3C}, {1'b0, 15'h7FFF, 8'hC3}, {1'b1, 15'h4166, 8'h96},
      {1'b0, 15'h0155, 8'h5A}, {1'b0, 15'h4166, 8'h96}, {1'b1, 15'h0000, 8'hFF},
      {1'b0, 15'h0000, 8'hFF}, {1'b1, 15'h2A2A, 8'h00}, {1'b0, 15'h2A2A, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ack;
   logic [7:0]  rsp_rdata;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i;

   int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_port_ctrl #(.CLK_NS(CLK_PERIOD)) u_dut (
      .clk (clk), .rst (rst), .req (req), .req_we (req_we),
      .req_addr (req_addr), .req_wdata (req_wdata), .ack (ack),
      .rsp_rdata (rsp_rdata), .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n),
      .mem_oe_n (mem_oe_n), .mem_addr (mem_addr), .mem_dq_o (mem_dq_o),
      .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
   );

   // ---------------- memory model ----------------
   logic [7:0] mem_arr [256];
   logic [6:0] tag_arr [256];
   int  rd_age;
   wire rd_win = !mem_ce_n && !mem_oe_n && mem_we_n;

   always_comb begin
      if (rd_win) begin
         if (rd_age < RD_CYC)                          mem_dq_i = 8'hEE;
         else if (tag_arr[mem_addr[7:0]] == mem_addr[14:8]) mem_dq_i = mem_arr[mem_addr[7:0]];
         else                                           mem_dq_i = 8'hA5;
      end else begin
         mem_dq_i = 8'h00;
      end
   end

   task automatic mcheck(input string tag, input int got, input int exp, input bit ok);
      mon_chk++;
      if (!ok) begin
         mon_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   int  wl, cl, ds, gap;
   bit  wwin_q, rd_q, rel_pend, gap_on, prev_ack, prev_we_n, prev_oe_n, moved, oe_bad;
   logic [7:0]  last_dq;
   logic [14:0] wr_addr;

   always @(negedge clk) begin
      if (rst) begin
         for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 8'h00;
            tag_arr[i] = 7'h7F;
         end
         rd_age = 0; wl = 0; cl = 0; ds = 0; gap = 0;
         wwin_q = 0; rd_q = 0; rel_pend = 0; gap_on = 0; prev_ack = 0;
         prev_we_n = 1; prev_oe_n = 1; moved = 0; oe_bad = 0;
         last_dq = '0; wr_addr = '0;
      end else begin
         automatic bit wwin = !mem_ce_n && !mem_we_n;
         // R6 no bus fight
         if (rd_win) mcheck("R6 drive during read", int'(mem_dq_oe), 0, !mem_dq_oe);
         // R3 release one cycle after write end
         if (rel_pend) begin
            mcheck("R3 bus released", int'(mem_dq_oe), 0, !mem_dq_oe);
            rel_pend = 0;
         end
         if (wwin) begin
            if (!wwin_q) begin wr_addr = mem_addr; moved = 0; oe_bad = 0; end
            if (mem_addr != wr_addr) moved = 1;
            if (!mem_oe_n) oe_bad = 1;
            // R3 no drive before the memory lets go
            if (mem_dq_oe) mcheck("R3 late drive", wl, LATE_CYC, wl >= LATE_CYC);
            if (mem_dq_oe) begin
               ds = (ds > 0 && mem_dq_o == last_dq) ? ds + 1 : 1;
               last_dq = mem_dq_o;
            end else begin
               ds = 0;
            end
         end else if (wwin_q) begin
            mcheck("R2 we pulse", wl, WP_CYC, wl >= WP_CYC);
            mcheck("R2 select lead", cl, SCE_CYC, cl >= SCE_CYC);
            mcheck("R2 address moved", int'(moved), 0, !moved);
            mcheck("R2 oe low in write", int'(oe_bad), 0, !oe_bad);
            mcheck("R3 data setup", ds, SD_CYC, ds >= SD_CYC);
            mcheck("R3 hold cycle", int'(mem_dq_oe), 1, mem_dq_oe);
            rel_pend = 1;
            mem_arr[wr_addr[7:0]] = last_dq;
            tag_arr[wr_addr[7:0]] = wr_addr[14:8];
            ds = 0;
         end
         // R6 gap after read
         if (rd_q && !rd_win) begin gap_on = 1; gap = 0; end
         if (gap_on) begin
            if (mem_ce_n) gap++;
            else begin
               mcheck("R6 read gap", gap, GAP_CYC, gap >= GAP_CYC);
               gap_on = 0;
            end
         end
         // R5 acknowledge placement
         if (ack) begin
            mcheck("R5 ack width", int'(prev_ack), 0, !prev_ack);
            mcheck("R5 ack after strobe", int'(prev_we_n && prev_oe_n), 0,
                   !(prev_we_n && prev_oe_n) && mem_we_n && mem_oe_n);
         end
         wl = wwin ? wl + 1 : 0;
         cl = !mem_ce_n ? cl + 1 : 0;
         rd_age = rd_win ? rd_age + 1 : 0;
         wwin_q = wwin; rd_q = rd_win;
         prev_ack = ack; prev_we_n = mem_we_n; prev_oe_n = mem_oe_n;
      end
   end

   // ---------------- stimulus ----------------
   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic run_txn(input logic w, input logic [14:0] a, input logic [7:0] d,
                          input int poke_at, output logic [7:0] rd, output bit ok);
      @(negedge clk);
      req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
      ok = 1'b0; rd = '0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (i == poke_at) begin
            req_we = ~w; req_addr = ~a; req_wdata = ~d;
         end
         if (ack) begin
            ok = 1'b1; rd = rsp_rdata;
            break;
         end
      end
      req = 1'b0;
   endtask

   initial begin
      logic [7:0] rd;
      bit ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ce_n", int'(mem_ce_n), 1);
      check("R1 we_n", int'(mem_we_n), 1);
      check("R1 oe_n", int'(mem_oe_n), 1);
      check("R1 dq_oe", int'(mem_dq_oe), 0);
      check("R1 ack", int'(ack), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 idle after reset", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);

      for (int v = 0; v < NVEC; v++) begin
         run_txn(VEC[v][23], VEC[v][22:8], VEC[v][7:0], -1, rd, ok);
         check("R5 ack seen", int'(ok), 1);
         if (!VEC[v][23]) check("R4 R8 read data", int'(rd), int'(VEC[v][7:0]));
      end

      // R7 fields changed mid-access must not matter
      run_txn(1'b1, 15'h1234, 8'h11, 2, rd, ok);
      check("R7 write ack", int'(ok), 1);
      run_txn(1'b0, 15'h1234, 8'h00, -1, rd, ok);
      check("R7 latched write", int'(rd), 8'h11);
      run_txn(1'b0, 15'h6DCB, 8'h00, -1, rd, ok);
      check("R7 poked address untouched", int'(rd), 8'hA5);
      run_txn(1'b0, 15'h7FFF, 8'h00, 1, rd, ok);
      check("R7 latched read", int'(rd), 8'hC3);
      // R7 no new access once idle with req low
      repeat (4) @(negedge clk);
      check("R7 idle strobes", int'({mem_ce_n, mem_we_n, mem_oe_n}), 3'b111);
      // R8 high address bit isolation
      run_txn(1'b0, 15'h4155, 8'h00, -1, rd, ok);
      check("R8 high address bits", int'(rd), 8'hA5);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk + mon_chk, n_fail + mon_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
         $finish;
      end
   end

endmodule